// File: doc/BRIEF.md
# Clocked Serial Shift Interface

This block is an 8-bit serial transmitter and receiver built around one shift register. Software writes the outgoing byte into the register through a parallel load and then issues a start strobe. Each serial clock period sends one bit out on `so`, most significant bit first, and takes one bit in from `si`. When the byte has been exchanged, the received data is read from the same register through `rd_data`. A completion flag reports the end of a byte. The flag stays set until a new start or an explicit clear.

A 2-bit mode field selects the serial clock.

- **Internal clock:** the block divides the system clock and drives the result out as the serial clock. After eight pulses it stops the clock by itself, with the serial clock parked high. A transfer therefore always takes the same fixed number of system cycles, so software can read or reload the register after a fixed wait without polling the flag.
- **External clock:** the serial clock comes in from a remote master through a synchronizer. The block never gates this clock. It counts eight rising edges to raise the flag, and any further pulses keep shifting.

Top module: `sio_xfer`

## Requirements
- R1: After reset, `rd_data` is 0, `done_flag` and `busy` are 0, `so` is 0 and `sck_out` is 1.
- R2: While `busy` is 0, a `load` pulse places `load_data` on `rd_data` one clock later. A `load` while `busy` is 1 is ignored and does not alter the byte received.
- R3: With `mode[1]` = 1 and `busy` = 0, a `start` pulse sets `busy` on the next clock. `sck_out` then alternates low and high, each phase HALF_CLKS system clocks, for eight pulses, starting with the low phase. `sck_out` is 1 whenever `busy` is 0 in this mode.
- R4: Data shifts most significant bit first. `so` takes the register's top bit at each serial clock fall, so during the k-th low phase (k from 0) `so` equals bit 7-k of the loaded byte. `si` is shifted into bit 0 at each rise, so after eight rises `rd_data` holds the first sampled bit in bit 7.
- R5: In internal mode, `busy` falls and `done_flag` rises exactly 16*HALF_CLKS clocks after the clock edge that accepts `start`.
- R6: With `mode` = 2'b01, `sck_in` passes through a two-flop synchronizer. Each synchronized rising edge shifts in `si`. `done_flag` is set, and `busy` cleared, on the eighth synchronized rise after `start`.
- R7: In external mode, rises after the eighth keep shifting `si` into the register and leave `done_flag` set.
- R8: A `start` while `busy` is 1 is ignored and does not delay completion.
- R9: `done_flag` is cleared by a `flag_clr` pulse or by an accepted `start`.
- R10: With `mode` = 2'b00, `start` is ignored, `sck_in` edges do not change the register, and `sck_oe` is 0.
- R11: `sck_oe` is 1 exactly when `mode[1]` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Clock source: 00 off, 01 external, 1x internal |
| start | input | 1 | Begin a byte transfer |
| load | input | 1 | Parallel write of the shift register |
| load_data | input | 8 | Byte to load |
| flag_clr | input | 1 | Clear the completion flag |
| sck_in | input | 1 | External serial clock |
| si | input | 1 | Serial data in |
| rd_data | output | 8 | Shift register contents |
| sck_out | output | 1 | Serial clock driven in internal mode |
| sck_oe | output | 1 | Output enable for the serial clock pin |
| so | output | 1 | Serial data out |
| busy | output | 1 | Transfer in progress |
| done_flag | output | 1 | Byte completion request flag |

## Verification
The bench exchanges random transmit and receive bytes in both clock modes. This separates the outgoing path on `so` from the incoming path on `si`, and shows whether the bit order is reversed or a bit is dropped. Directed internal-mode transfers inject a second start and a load in the middle of a byte. These show whether busy-time requests are filtered, and whether the completion cycle stays fixed. Extra external pulses after the eighth show that the clock is not gated and that the flag stays set. An off-mode pattern shows that start and the serial clock have no effect there.

// File: rtl/sio_pkg.sv
package sio_pkg;
  typedef struct packed {
    logic fall;
    logic rise;
  } sio_edge_t;

  localparam logic [1:0] SIO_MODE_OFF = 2'b00;
  localparam logic [1:0] SIO_MODE_EXT = 2'b01;

  function automatic logic sio_is_int(input logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/sio_sync_edge.sv
module sio_sync_edge
  import sio_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      sck_in,
  output sio_edge_t edge_o
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= 1'b1;
    else     chain_q[0] <= sck_in;
  end

  genvar gi;
  generate
    for (gi = 1; gi <= STAGES; gi++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain_q[gi] <= 1'b1;
        else     chain_q[gi] <= chain_q[gi-1];
      end
    end
  endgenerate

  assign edge_o.rise = chain_q[STAGES-1] & ~chain_q[STAGES];
  assign edge_o.fall = ~chain_q[STAGES-1] & chain_q[STAGES];
endmodule

// File: rtl/sio_intclk.sv
module sio_intclk
  import sio_pkg::*;
#(
  parameter int HALF_CLKS = 1
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      run,
  output logic      sck_q,
  output sio_edge_t edge_o
);
  localparam int DW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
  localparam logic [DW-1:0] DLAST = DW'(HALF_CLKS - 1);

  logic [DW-1:0] div_q;
  logic          tick;

  assign tick = run && (div_q == DLAST);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      div_q <= '0;
      sck_q <= 1'b1;
    end else if (tick) begin
      div_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign edge_o.fall = tick & sck_q;
  assign edge_o.rise = tick & ~sck_q;
endmodule

// File: rtl/sio_ctrl.sv
module sio_ctrl
  import sio_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic      clk,
  input  logic      rst,
  input  logic [1:0] mode,
  input  logic      start,
  input  logic      load,
  input  logic      flag_clr,
  input  sio_edge_t int_edge,
  input  sio_edge_t ext_edge,
  output sio_edge_t shift_edge,
  output logic      load_en,
  output logic      int_run,
  output logic      busy_q,
  output logic      flag_q
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] CLAST = CW'(WIDTH - 1);

  logic [CW-1:0] cnt_q;
  logic          start_ok;
  logic          last_rise;

  always_comb begin
    if (sio_is_int(mode))         shift_edge = int_edge;
    else if (mode == SIO_MODE_EXT) shift_edge = ext_edge;
    else                           shift_edge = '0;
  end

  assign start_ok  = start && !busy_q && (mode != SIO_MODE_OFF);
  assign last_rise = busy_q && shift_edge.rise && (cnt_q == CLAST);
  assign load_en   = load && !busy_q;
  assign int_run   = busy_q && sio_is_int(mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_ok) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q && shift_edge.rise) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CLAST) busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                       flag_q <= 1'b0;
    else if (last_rise)            flag_q <= 1'b1;
    else if (start_ok || flag_clr) flag_q <= 1'b0;
  end

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !shift_edge.rise) |=> (busy_q && $stable(cnt_q)));

  // R5
  flag_end_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $fell(busy_q));

  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(WIDTH));
endmodule

// File: rtl/sio_shreg.sv
module sio_shreg
  import sio_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [WIDTH-1:0] load_data,
  input  sio_edge_t        edge_i,
  input  logic             si,
  output logic [WIDTH-1:0] shreg_q,
  output logic             so_q
);
  always_ff @(posedge clk) begin
    if (rst)              shreg_q <= '0;
    else if (load_en)     shreg_q <= load_data;
    else if (edge_i.rise) shreg_q <= {shreg_q[WIDTH-2:0], si};
  end

  always_ff @(posedge clk) begin
    if (rst)              so_q <= 1'b0;
    else if (edge_i.fall) so_q <= shreg_q[WIDTH-1];
  end

  // R2
  shreg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_en && !edge_i.rise) |=> $stable(shreg_q));

  // R4
  so_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !edge_i.fall |=> $stable(so_q));
endmodule

// File: rtl/sio_xfer.sv
module sio_xfer
  import sio_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int HALF_CLKS   = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic             start,
  input  logic             load,
  input  logic [WIDTH-1:0] load_data,
  input  logic             flag_clr,
  input  logic             sck_in,
  input  logic             si,
  output logic [WIDTH-1:0] rd_data,
  output logic             sck_out,
  output logic             sck_oe,
  output logic             so,
  output logic             busy,
  output logic             done_flag
);
  sio_edge_t int_edge, ext_edge, shift_edge;
  logic      load_en, int_run;

  sio_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sck_in(sck_in), .edge_o(ext_edge)
  );

  sio_intclk #(.HALF_CLKS(HALF_CLKS)) u_intclk (
    .clk(clk), .rst(rst), .run(int_run), .sck_q(sck_out), .edge_o(int_edge)
  );

  sio_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst(rst), .mode(mode), .start(start), .load(load),
    .flag_clr(flag_clr), .int_edge(int_edge), .ext_edge(ext_edge),
    .shift_edge(shift_edge), .load_en(load_en), .int_run(int_run),
    .busy_q(busy), .flag_q(done_flag)
  );

  sio_shreg #(.WIDTH(WIDTH)) u_shreg (
    .clk(clk), .rst(rst), .load_en(load_en), .load_data(load_data),
    .edge_i(shift_edge), .si(si), .shreg_q(rd_data), .so_q(so)
  );

  assign sck_oe = sio_is_int(mode);

  // R3
  park_high_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && sio_is_int(mode)) |-> sck_out);
endmodule

// File: tb/sio_xfer_test.sv
module sio_xfer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'b00;
  logic       start = 1'b0, load = 1'b0, flag_clr = 1'b0;
  logic [7:0] load_data = 8'h00;
  logic       sck_in = 1'b1, si = 1'b0;
  logic [7:0] rd_data;
  logic       sck_out, sck_oe, so, busy, done_flag;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sio_xfer #(.WIDTH(8), .HALF_CLKS(1), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .mode(mode), .start(start), .load(load),
    .load_data(load_data), .flag_clr(flag_clr), .sck_in(sck_in), .si(si),
    .rd_data(rd_data), .sck_out(sck_out), .sck_oe(sck_oe), .so(so),
    .busy(busy), .done_flag(done_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic tx_bit(input logic [7:0] b, input int k);
    return b[7-k];
  endfunction

  function automatic logic [7:0] after_extra(input logic [7:0] r, input logic b);
    return {r[6:0], b};
  endfunction

  task automatic do_load(input logic [7:0] d);
    @(negedge clk); load = 1'b1; load_data = d;
    @(negedge clk); load = 1'b0;
  endtask

  task automatic int_xfer(input logic [7:0] tx, input logic [7:0] rx,
                          input logic [1:0] m, input bit disturb);
    int so_err = 0, sck_err = 0, busy_err = 0;
    mode = m;
    do_load(tx);
    chk("R11 sck_oe internal", sck_oe, 1);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R3 busy after start", busy, 1);
    chk("R9 flag cleared by start", done_flag, 0);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (sck_out !== 1'b0) sck_err++;
      if (so !== tx_bit(tx, k)) so_err++;
      si = rx[7-k];
      if (disturb && k == 2) start = 1'b1;
      if (disturb && k == 3) begin load = 1'b1; load_data = ~tx; end
      @(negedge clk);
      start = 1'b0; load = 1'b0;
      if (sck_out !== 1'b1) sck_err++;
      if (k < 7 && busy !== 1'b1) busy_err++;
    end
    chk("R3 sck_out phases", sck_err, 0);
    chk("R4 so msb first", so_err, 0);
    chk(disturb ? "R8 busy held despite restart" : "R5 busy held", busy_err, 0);
    chk(disturb ? "R8 completion timing" : "R5 completion timing", busy, 0);
    chk("R5 flag at 16 clocks", done_flag, 1);
    chk("R3 sck parked high", sck_out, 1);
    chk(disturb ? "R2 busy load ignored" : "R4 received byte", rd_data, rx);
  endtask

  task automatic ext_pulse(input logic b);
    @(negedge clk); sck_in = 1'b0;
    repeat (4) @(negedge clk);
    si = b; sck_in = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic ext_xfer(input logic [7:0] tx, input logic [7:0] rx, input logic xb);
    int so_err = 0;
    mode = 2'b01; sck_in = 1'b1;
    do_load(tx);
    repeat (4) @(negedge clk);
    chk("R11 sck_oe external", sck_oe, 0);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R6 busy after start", busy, 1);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); sck_in = 1'b0;
      repeat (4) @(negedge clk);
      if (so !== tx_bit(tx, k)) so_err++;
      si = rx[7-k]; sck_in = 1'b1;
      repeat (4) @(negedge clk);
      if (k == 6) begin
        chk("R6 no flag after seven", done_flag, 0);
        chk("R6 busy after seven", busy, 1);
      end
    end
    chk("R4 so msb first ext", so_err, 0);
    chk("R6 flag on eighth", done_flag, 1);
    chk("R6 busy cleared", busy, 0);
    chk("R6 received byte", rd_data, rx);
    ext_pulse(xb);
    chk("R7 extra pulse shifts", rd_data, after_extra(rx, xb));
    chk("R7 flag stays set", done_flag, 1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 flag", done_flag, 0);
    chk("R1 busy", busy, 0);
    chk("R1 so", so, 0);
    chk("R1 sck_out", sck_out, 1);

    // mode off
    chk("R10 sck_oe off", sck_oe, 0);
    do_load(8'hA5);
    chk("R2 load idle", rd_data, 8'hA5);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    chk("R10 start ignored", busy, 0);
    ext_pulse(1'b1);
    ext_pulse(1'b0);
    chk("R10 sck_in ignored", rd_data, 8'hA5);

    int_xfer(8'h96, 8'h3C, 2'b10, 1'b1);
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    chk("R9 flag_clr", done_flag, 0);
    int_xfer(8'h01, 8'h80, 2'b11, 1'b0);
    for (int i = 0; i < 6; i++)
      int_xfer(8'($urandom), 8'($urandom), (i % 2) ? 2'b11 : 2'b10, 1'(i == 3));

    ext_xfer(8'hF0, 8'h5A, 1'b1);
    for (int i = 0; i < 4; i++)
      ext_xfer(8'($urandom), 8'($urandom), 1'($urandom));

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule